// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block sits between the command generator of a memory controller and the command pins of a four-bank double-data-rate SDRAM. On every cycle it decodes the command on the active-low chip-select, row-strobe, column-strobe and write-enable lines, together with the two bank-select bits and the auto/all address bit. It then decides whether the command may go to the device in that same cycle. It keeps one small state machine per bank that records whether the bank holds an open row and how many cycles have passed since the bank's last activate. A separate timer counts the cycles since the most recent activate to any bank.

The decision has three outcomes. A command that meets every rule passes through unchanged. A command that is legal but early is held: `stall` goes high and the device sees a deselect until the timers allow it. The requester keeps presenting the same command while `stall` is high. A command that can never be legal in the current bank state is rejected: `illegal` goes high for that cycle, the device sees a deselect, and the requester is expected to move on. Illegal commands are a column access to a closed bank and an activate to a bank that is already open.

Each bank's state machine has three states. `BK_IDLE` means the bank is closed. `BK_WAKING` means the bank is open but still inside its activate-to-column window. `BK_ACTIVE` means the bank is open and column commands are allowed. The transitions are:
- open: from `BK_IDLE` to `BK_WAKING` on an issued activate, or straight to `BK_ACTIVE` when the activate-to-column limit is one cycle.
- ripen: from `BK_WAKING` to `BK_ACTIVE` when the cycle count reaches the activate-to-column limit.
- close: from `BK_WAKING` or `BK_ACTIVE` to `BK_IDLE` on an issued precharge for that bank, or on a precharge to all banks.

The verdict logic names its three outcomes `V_PASS`, `V_WAIT` and `V_REJECT`.

Top module: `ddr_bank_guard`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: activate = 0011, read = 0101, write = 0100, precharge = 0010. Any other pattern, including no-operation (0111), deselect (1xxx) and the 0001 refresh-type pattern, is forwarded unchanged with its bank and A10 bits.
- R2: A command that breaks no rule reaches the device outputs in the same cycle, with identical strobes, bank and A10, and with `stall` and `illegal` low.
- R3: A read or write to a bank is held (`stall` high) until at least `TRCD` rising edges have passed since that bank's activate was issued. It is forwarded on the first cycle that meets this count.
- R4: Any activate is held until at least `TRRD` rising edges have passed since the previous issued activate to any bank.
- R5: An activate to a bank is held until at least `TRC` rising edges have passed since that same bank's previous activate, even if the bank was precharged in between.
- R6: An activate to a bank that is open is rejected: `illegal` high, `stall` low, nothing issued, and the bank stays open.
- R7: A read or write to a closed bank is rejected: `illegal` high, `stall` low, nothing issued.
- R8: A precharge with A10 = 0 closes only the bank it selects. A precharge with A10 = 1 closes all four banks. A precharge is always forwarded.
- R9: Whenever a command is held or rejected, the device outputs are cs_n = ras_n = cas_n = we_n = 1, bank = 0 and A10 = 0.
- R10: Reset closes every bank and expires every timer, so an activate presented in the first cycle after reset is forwarded at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cs_n | input | 1 | Requested chip-select, active low |
| req_ras_n | input | 1 | Requested row strobe, active low |
| req_cas_n | input | 1 | Requested column strobe, active low |
| req_we_n | input | 1 | Requested write enable, active low |
| req_bank | input | 2 | Requested bank select |
| req_a10 | input | 1 | Requested address bit 10 (all-banks flag for precharge) |
| dev_cs_n | output | 1 | Chip-select to the device |
| dev_ras_n | output | 1 | Row strobe to the device |
| dev_cas_n | output | 1 | Column strobe to the device |
| dev_we_n | output | 1 | Write enable to the device |
| dev_bank | output | 2 | Bank select to the device |
| dev_a10 | output | 1 | Address bit 10 to the device |
| stall | output | 1 | Command is legal but early; hold it |
| illegal | output | 1 | Command is rejected for the current bank state |

## Verification
The hardest case to reach from the ports is the row-cycle limit acting alone. A same-bank activate is normally rejected because the bank is still open, and the cross-bank spacing often hides the row-cycle count. To isolate it, the bench activates a bank, precharges it in the next cycle, and then presents a second activate to the same bank. That activate is past the cross-bank spacing and the bank is closed, so only the row-cycle count can hold it, and the bench checks that the hold lasts exactly TRC - 2 cycles. The activate-to-column window is tested the same way: a column command is presented on the very cycle after the activate, and the bench counts the stall cycles.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_READ,
        CMD_WRITE,
        CMD_PRE,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_WAKING,
        BK_ACTIVE
    } bank_st_e;

    typedef enum logic [1:0] {
        V_PASS,
        V_WAIT,
        V_REJECT
    } verdict_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_guard_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/ddr_act_spacer.sv
module ddr_act_spacer #(
    parameter int TRRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_fire,
    output logic rrd_ready
);
    localparam int AGE_W = (TRRD < 2) ? 1 : $clog2(TRRD + 1);
    localparam logic [AGE_W-1:0] LIMIT = AGE_W'(TRRD);

    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= LIMIT;
        end else if (act_fire) begin
            age_q <= AGE_W'(1);
        end else if (age_q < LIMIT) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    assign rrd_ready = (age_q >= LIMIT);

    assert_act_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> age_q >= LIMIT);

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_guard_pkg::*;
#(
    parameter int TRCD = 3,
    parameter int TRC  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_fire,
    input  logic pre_fire,
    output logic is_open,
    output logic col_ready,
    output logic rc_ready
);
    localparam int SAT   = (TRC > TRCD) ? TRC : TRCD;
    localparam int AGE_W = (SAT < 2) ? 1 : $clog2(SAT + 1);
    localparam logic [AGE_W-1:0] SAT_A  = AGE_W'(SAT);
    localparam logic [AGE_W-1:0] TRCD_A = AGE_W'(TRCD);
    localparam logic [AGE_W-1:0] TRC_A  = AGE_W'(TRC);

    bank_st_e         state_q, state_d;
    logic [AGE_W-1:0] age_q;

    // cycles since this bank's last activate, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= SAT_A;
        end else if (act_fire) begin
            age_q <= AGE_W'(1);
        end else if (age_q < SAT_A) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    // transitions: open, ripen, close
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE: begin
                if (act_fire) state_d = (TRCD <= 1) ? BK_ACTIVE : BK_WAKING;
            end
            BK_WAKING: begin
                if (pre_fire)                              state_d = BK_IDLE;
                else if ((age_q + AGE_W'(1)) >= TRCD_A)   state_d = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (pre_fire) state_d = BK_IDLE;
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        is_open   = (state_q != BK_IDLE);
        col_ready = (state_q == BK_ACTIVE);
        rc_ready  = (age_q >= TRC_A);
    end

    assert_col_after_trcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_ready |-> age_q >= TRCD_A);

    assert_reopen_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> age_q >= TRC_A);

    assert_act_only_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> state_q == BK_IDLE);

    assert_pre_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fire |=> state_q == BK_IDLE);

endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
    import ddr_guard_pkg::*;
#(
    parameter int TRCD   = 3,
    parameter int TRRD   = 2,
    parameter int TRC    = 7,
    parameter int BANKS  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_cs_n,
    input  logic       req_ras_n,
    input  logic       req_cas_n,
    input  logic       req_we_n,
    input  logic [1:0] req_bank,
    input  logic       req_a10,
    output logic       dev_cs_n,
    output logic       dev_ras_n,
    output logic       dev_cas_n,
    output logic       dev_we_n,
    output logic [1:0] dev_bank,
    output logic       dev_a10,
    output logic       stall,
    output logic       illegal
);
    localparam int BANK_W = $clog2(BANKS);

    cmd_e             cmd;
    verdict_e         verdict;
    logic [BANKS-1:0] bank_open, bank_col_ok, bank_rc_ok;
    logic [BANKS-1:0] act_fire_b, pre_fire_b;
    logic             rrd_ok, act_fire;
    logic [BANK_W-1:0] sel;

    assign sel = BANK_W'(req_bank);

    ddr_cmd_decode u_dec (
        .cs_n (req_cs_n),
        .ras_n(req_ras_n),
        .cas_n(req_cas_n),
        .we_n (req_we_n),
        .cmd  (cmd)
    );

    ddr_act_spacer #(.TRRD(TRRD)) u_rrd (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fire (act_fire),
        .rrd_ready(rrd_ok)
    );

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        assign act_fire_b[i] = act_fire && (sel == BANK_W'(i));
        assign pre_fire_b[i] = (cmd == CMD_PRE) && (req_a10 || sel == BANK_W'(i));

        ddr_bank_tracker #(.TRCD(TRCD), .TRC(TRC)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_fire (act_fire_b[i]),
            .pre_fire (pre_fire_b[i]),
            .is_open  (bank_open[i]),
            .col_ready(bank_col_ok[i]),
            .rc_ready (bank_rc_ok[i])
        );
    end

    // verdict: rejection outranks waiting
    always_comb begin
        verdict = V_PASS;
        unique case (cmd)
            CMD_ACT: begin
                if (bank_open[sel])                    verdict = V_REJECT;
                else if (!(rrd_ok && bank_rc_ok[sel])) verdict = V_WAIT;
            end
            CMD_READ, CMD_WRITE: begin
                if (!bank_open[sel])                   verdict = V_REJECT;
                else if (!bank_col_ok[sel])            verdict = V_WAIT;
            end
            default: verdict = V_PASS;
        endcase
    end

    assign act_fire = (cmd == CMD_ACT) && (verdict == V_PASS);

    // device-side outputs
    always_comb begin
        stall   = (verdict == V_WAIT);
        illegal = (verdict == V_REJECT);
        if (verdict == V_PASS) begin
            dev_cs_n  = req_cs_n;
            dev_ras_n = req_ras_n;
            dev_cas_n = req_cas_n;
            dev_we_n  = req_we_n;
            dev_bank  = req_bank;
            dev_a10   = req_a10;
        end else begin
            dev_cs_n  = 1'b1;
            dev_ras_n = 1'b1;
            dev_cas_n = 1'b1;
            dev_we_n  = 1'b1;
            dev_bank  = 2'b00;
            dev_a10   = 1'b0;
        end
    end

    assert_blocked_is_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || illegal) |-> (dev_cs_n && dev_ras_n && dev_cas_n && dev_we_n
                                && dev_bank == 2'b00 && !dev_a10));

    assert_col_needs_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_cs_n && dev_ras_n && !dev_cas_n) |-> bank_open[BANK_W'(dev_bank)]);

    assert_stall_reject_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && illegal));

    assert_act_bank_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_cs_n && !dev_ras_n && dev_cas_n && dev_we_n) |=> bank_open[BANK_W'($past(dev_bank))]);

endmodule

// File: tb/ddr_bank_guard_test.sv
`timescale 1ns/1ps
module ddr_bank_guard_test;
    localparam int TRCD = 3;
    localparam int TRRD = 2;
    localparam int TRC  = 7;

    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DES = 4'b1111;
    localparam logic [3:0] C_REF = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] bank = 2'b00;
    logic a10 = 1'b0;
    logic d_cs, d_ras, d_cas, d_we, d_a10, stall, illegal;
    logic [1:0] d_bank;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ddr_bank_guard #(.TRCD(TRCD), .TRRD(TRRD), .TRC(TRC)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_cs_n(cs_n), .req_ras_n(ras_n), .req_cas_n(cas_n), .req_we_n(we_n),
        .req_bank(bank), .req_a10(a10),
        .dev_cs_n(d_cs), .dev_ras_n(d_ras), .dev_cas_n(d_cas), .dev_we_n(d_we),
        .dev_bank(d_bank), .dev_a10(d_a10),
        .stall(stall), .illegal(illegal)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic a);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        bank = b;
        a10 = a;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(C_NOP, 2'b00, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = C_DES;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_pass(input string tag, input logic [3:0] c,
                               input logic [1:0] b, input logic a);
        check({tag, " forwarded strobes"}, int'({d_cs, d_ras, d_cas, d_we}), int'(c));
        check({tag, " forwarded bank/a10"}, int'({d_bank, d_a10}), int'({b, a}));
        check({tag, " stall/illegal low"}, int'({stall, illegal}), 0);
    endtask

    task automatic expect_block(input string tag, input logic st, input logic il);
        check({tag, " device sees deselect"}, int'({d_cs, d_ras, d_cas, d_we, d_bank, d_a10}), 8'hF0 >> 1);
        check({tag, " stall/illegal"}, int'({stall, illegal}), int'({st, il}));
    endtask

    task automatic wait_go(output int n);
        n = 0;
        while (stall && n < 100) begin
            @(negedge clk);
            #1;
            n++;
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        drive(C_NOP, 2'b00, 1'b0);
        expect_pass("R10 reset idle", C_NOP, 2'b00, 1'b0);
        drive(C_RD, 2'b00, 1'b0);
        expect_block("R10 read after reset, banks closed", 1'b0, 1'b1);
        drive(C_ACT, 2'b01, 1'b0);
        expect_pass("R10 first activate", C_ACT, 2'b01, 1'b0);
    endtask

    task automatic t_passthrough();
        do_reset();
        drive(C_REF, 2'b11, 1'b1);
        expect_pass("R1 refresh-type pattern", C_REF, 2'b11, 1'b1);
        drive(C_DES, 2'b10, 1'b1);
        expect_pass("R1 deselect", C_DES, 2'b10, 1'b1);
        drive(C_PRE, 2'b10, 1'b0);
        expect_pass("R2 precharge of closed bank", C_PRE, 2'b10, 1'b0);
    endtask

    task automatic t_trcd();
        int n;
        do_reset();
        drive(C_ACT, 2'b01, 1'b0);
        expect_pass("R3 activate", C_ACT, 2'b01, 1'b0);
        drive(C_WR, 2'b01, 1'b0);
        expect_block("R9 early write held", 1'b1, 1'b0);
        wait_go(n);
        check("R3 write stall cycles", n, TRCD - 1);
        expect_pass("R3 write after tRCD", C_WR, 2'b01, 1'b0);
        drive(C_RD, 2'b01, 1'b1);
        expect_pass("R3 read follows", C_RD, 2'b01, 1'b1);
    endtask

    task automatic t_trrd();
        int n;
        do_reset();
        drive(C_ACT, 2'b00, 1'b0);
        drive(C_ACT, 2'b11, 1'b0);
        expect_block("R4 second activate held", 1'b1, 1'b0);
        wait_go(n);
        check("R4 activate spacing stall cycles", n, TRRD - 1);
        expect_pass("R4 activate after tRRD", C_ACT, 2'b11, 1'b0);
        idle(TRRD);
        drive(C_ACT, 2'b10, 1'b0);
        expect_pass("R4 spaced activate immediate", C_ACT, 2'b10, 1'b0);
    endtask

    task automatic t_trc();
        int n;
        do_reset();
        drive(C_ACT, 2'b10, 1'b0);
        drive(C_PRE, 2'b10, 1'b0);
        expect_pass("R8 precharge forwarded", C_PRE, 2'b10, 1'b0);
        drive(C_ACT, 2'b10, 1'b0);
        expect_block("R5 reactivate held", 1'b1, 1'b0);
        wait_go(n);
        check("R5 row cycle stall cycles", n, TRC - 2);
        expect_pass("R5 reactivate after tRC", C_ACT, 2'b10, 1'b0);
    endtask

    task automatic t_reopen_and_reset();
        do_reset();
        drive(C_ACT, 2'b00, 1'b0);
        idle(TRC);
        drive(C_ACT, 2'b00, 1'b0);
        expect_block("R6 activate to open bank", 1'b0, 1'b1);
        idle(TRCD);
        drive(C_RD, 2'b00, 1'b0);
        expect_pass("R6 bank stayed open", C_RD, 2'b00, 1'b0);
        do_reset();
        drive(C_ACT, 2'b00, 1'b0);
        expect_pass("R10 reset clears open bank and timers", C_ACT, 2'b00, 1'b0);
    endtask

    task automatic t_precharge();
        do_reset();
        drive(C_ACT, 2'b00, 1'b0);
        idle(TRRD);
        drive(C_ACT, 2'b01, 1'b0);
        idle(TRCD);
        drive(C_PRE, 2'b00, 1'b0);
        expect_pass("R8 single precharge", C_PRE, 2'b00, 1'b0);
        drive(C_RD, 2'b00, 1'b0);
        expect_block("R7 read to precharged bank", 1'b0, 1'b1);
        drive(C_RD, 2'b01, 1'b0);
        expect_pass("R8 other bank still open", C_RD, 2'b01, 1'b0);
        drive(C_PRE, 2'b10, 1'b1);
        expect_pass("R8 precharge all", C_PRE, 2'b10, 1'b1);
        drive(C_WR, 2'b01, 1'b0);
        expect_block("R8 write after precharge all", 1'b0, 1'b1);
        drive(C_WR, 2'b11, 1'b0);
        expect_block("R7 write to never-opened bank", 1'b0, 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_passthrough();
        t_trcd();
        t_trrd();
        t_trc();
        t_reopen_and_reset();
        t_precharge();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule